// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block manages one external non-maskable interrupt request. The pin is asynchronous, so it first passes through a synchronizer. A small detector then compares the pin against one of four trigger conditions: an active-low level, an active-high level, a falling edge or a rising edge. When the condition is met, the detector raises a sticky pending flag. When software has enabled the line, the pending flag drives a registered interrupt output toward the processor.

Software reaches the block through a simple 32-bit register port with three registers: a mode/control word, a pending flag that software clears by writing one, and an enable flag. The control word sits at offset zero. A parameter sets the offsets of the pending and enable registers, so the block fits three address layouts.

The driver uses the block as follows. After reset it masks the line and throws away any stale event. It picks a trigger mode with a read-modify-write of the control word. It then unmasks the line. For edge triggers, software acknowledges by clearing pending before it services the request. For level triggers, software clears pending when servicing is done.

Top module: `nmi_line_ctrl`

## Requirements
- R1: While reset is held, the control, pending and enable registers all read back as zero, and `nmiIrq` is low.
- R2: The control register holds and returns all 32 written bits. Only bits [1:0] choose the trigger: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge.
- R3: In mode 0, pending becomes set while the synchronized pin is low.
- R4: In mode 2, pending becomes set while the synchronized pin is high. A clear while the pin is low leaves pending at zero.
- R5: In mode 1, pending becomes set only when the synchronized pin goes from high to low. After a clear it stays zero while the pin holds steady, and a rising transition does not set it.
- R6: In mode 3, pending becomes set only when the synchronized pin goes from low to high. After a clear it stays zero while the pin holds steady, and a falling transition does not set it.
- R7: Writing a word with bit 0 set to the pending register clears pending. Writing a word with bit 0 clear does nothing. Pending reads back in bit 0 only, and the upper bits read as zero.
- R8: If a trigger condition and a pending clear fall in the same cycle, pending stays set.
- R9: A pin change made after clock edge k shows in pending after edge k+3 (two synchronizer stages, then the latch). `nmiIrq` follows (pending AND enable bit 0) one clock later. The enable register reads back in bit 0 only.
- R10: `LAYOUT` picks the offsets. With 0, pending is at 0x04 and enable at 0x08. With 1, enable is at 0x04 and pending at 0x08. With 2, pending is at 0x04 and enable at 0x34.
- R11: A read of any offset that is not mapped returns zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| nmiPin | input | 1 | Asynchronous external interrupt request |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational, zero when no read |
| nmiIrq | output | 1 | Registered interrupt request to the processor |

## Verification
Two things can fall in the same clock edge: a software write-one-to-clear of pending and a trigger condition from the detector. In level modes, the bench provokes this by clearing pending while the active level is still on the synchronized pin. The requirement counts as met when pending reads back as one in the following cycle. Checkers also watch the same collision in the active-high mode cycle by cycle, along with the reverse case, where a clear with the level inactive must leave pending at zero.

// File: rtl/nmi_ctrl_pkg.sv
package nmi_ctrl_pkg;

  // Trigger codes held in control bits [1:0]
  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_LVL_HIGH = 2'd2,
    TRIG_RISE     = 2'd3
  } trigMode_t;

  // Strobes and state handed from the register control to the datapath
  typedef struct packed {
    logic      pendClr;
    logic      enable;
    trigMode_t mode;
  } nmiStrobe_t;

  localparam int LAYOUT_STD    = 0;
  localparam int LAYOUT_SWAP   = 1;
  localparam int LAYOUT_LEGACY = 2;

  localparam int CTRL_OFFSET = 'h00;

  function automatic int pendOffset(int layout);
    case (layout)
      LAYOUT_SWAP: return 'h08;
      default:     return 'h04;
    endcase
  endfunction

  function automatic int enOffset(int layout);
    case (layout)
      LAYOUT_SWAP:   return 'h04;
      LAYOUT_LEGACY: return 'h34;
      default:       return 'h08;
    endcase
  endfunction

endpackage

// File: rtl/nmi_ctrl_regif.sv
module nmi_ctrl_regif
  import nmi_ctrl_pkg::*;
#(
  parameter int LAYOUT = LAYOUT_STD,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              pendingQ,
  output logic [DATA_W-1:0] busRdata,
  output nmiStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFFSET);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(pendOffset(LAYOUT));
  localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(enOffset(LAYOUT));

  logic [DATA_W-1:0] ctrlQ;
  logic              enableQ;
  logic              hitCtrl, hitPend, hitEn;
  logic              wrAccess, rdAccess;

  assign hitCtrl  = (busAddr == CTRL_ADDR);
  assign hitPend  = (busAddr == PEND_ADDR);
  assign hitEn    = (busAddr == EN_ADDR);
  assign wrAccess = busSel && busWrite;
  assign rdAccess = busSel && !busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      enableQ <= 1'b0;
    end else begin
      if (wrAccess && hitCtrl) ctrlQ   <= busWdata;
      if (wrAccess && hitEn)   enableQ <= busWdata[0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (rdAccess) begin
      if (hitCtrl)      busRdata = ctrlQ;
      else if (hitPend) busRdata[0] = pendingQ;
      else if (hitEn)   busRdata[0] = enableQ;
    end
  end

  always_comb begin
    strobe.pendClr = wrAccess && hitPend && busWdata[0];
    strobe.enable  = enableQ;
    strobe.mode    = trigMode_t'(ctrlQ[1:0]);
  end

endmodule

// File: rtl/nmi_ctrl_core.sv
module nmi_ctrl_core
  import nmi_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinAsync,
  input  nmiStrobe_t strobe,
  output logic       pendingQ,
  output logic       irqQ,
  output logic       syncLevel,
  output logic       prevLevel
);

  localparam int CHAIN_W = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [CHAIN_W-1:0] syncChain;
  logic               eventHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[CHAIN_W-2:0], pinAsync};
  end

  assign syncLevel = syncChain[CHAIN_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncLevel;
  end

  always_comb begin
    unique case (strobe.mode)
      TRIG_LVL_LOW:  eventHit = !syncLevel;
      TRIG_FALL:     eventHit = !syncLevel && prevLevel;
      TRIG_LVL_HIGH: eventHit = syncLevel;
      TRIG_RISE:     eventHit = syncLevel && !prevLevel;
      default:       eventHit = 1'b0;
    endcase
  end

  // Detection outranks a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pendingQ <= 1'b0;
    else if (eventHit)       pendingQ <= 1'b1;
    else if (strobe.pendClr) pendingQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= pendingQ && strobe.enable;
  end

endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_ctrl_pkg::*;
#(
  parameter int LAYOUT      = LAYOUT_STD,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiPin,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              nmiIrq
);

  nmiStrobe_t strobe;
  logic       pendingQ;
  logic       syncLevel;
  logic       prevLevel;

  nmi_ctrl_regif #(
    .LAYOUT(LAYOUT),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regif (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .pendingQ (pendingQ),
    .busRdata (busRdata),
    .strobe   (strobe)
  );

  nmi_ctrl_core #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_core (
    .clk       (clk),
    .rstN      (rstN),
    .pinAsync  (nmiPin),
    .strobe    (strobe),
    .pendingQ  (pendingQ),
    .irqQ      (nmiIrq),
    .syncLevel (syncLevel),
    .prevLevel (prevLevel)
  );

endmodule

// File: rtl/nmi_line_ctrl_chk.sv
module nmi_line_ctrl_chk
  import nmi_ctrl_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       irq,
  input logic       pendingQ,
  input nmiStrobe_t strobe,
  input logic       syncLevel,
  input logic       prevLevel
);

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq == $past(pendingQ && strobe.enable))
    else $error("irq does not follow pending and enable");

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enable |=> !irq)
    else $error("irq raised while masked");

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pendClr && strobe.mode == TRIG_LVL_HIGH && !syncLevel) |=> !pendingQ)
    else $error("clear ignored");

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pendClr && strobe.mode == TRIG_LVL_HIGH && syncLevel) |=> pendingQ)
    else $error("clear beat a live event");

  p_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == TRIG_RISE && syncLevel && !prevLevel) |=> pendingQ)
    else $error("rising edge missed");

  p_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == TRIG_FALL && !syncLevel && prevLevel) |=> pendingQ)
    else $error("falling edge missed");

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !strobe.pendClr) |=> pendingQ)
    else $error("pending dropped without clear");

endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irq       (nmiIrq),
  .pendingQ  (pendingQ),
  .strobe    (strobe),
  .syncLevel (syncLevel),
  .prevLevel (prevLevel)
);

// File: tb/tb_nmi_line_ctrl.sv
`timescale 1ns/1ps
module tb_nmi_line_ctrl;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              nmiPin = 1'b1;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata, rdAlt, rdLeg;
  logic              nmiIrq, irqAlt, irqLeg;

  int   errors = 0;
  int   checks = 0;
  logic obsValid = 1'b0;
  logic finished = 1'b0;

  int          selQ[$];
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  nmi_line_ctrl #(.LAYOUT(0)) dut (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .nmiIrq(nmiIrq));

  nmi_line_ctrl #(.LAYOUT(1)) dutAlt (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdAlt), .nmiIrq(irqAlt));

  nmi_line_ctrl #(.LAYOUT(2)) dutLeg (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdLeg), .nmiIrq(irqLeg));

  // Monitor: pops one expected item per observed cycle
  always @(negedge clk) begin
    if (obsValid && selQ.size() > 0) begin
      int          sel;
      logic [31:0] exp;
      logic [31:0] act;
      string       tag;
      sel = selQ.pop_front();
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      case (sel)
        0:       act = busRdata;
        1:       act = {31'd0, nmiIrq};
        2:       act = rdAlt;
        default: act = rdLeg;
      endcase
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    busSel = 1'b0;
    busWrite = 1'b0;
    obsValid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    tick();
    busSel = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
  endtask

  task automatic rdSel(input int sel, input logic [7:0] addr, input logic [31:0] exp, input string tag);
    tick();
    busSel = 1'b1; busWrite = 1'b0; busAddr = addr;
    selQ.push_back(sel); expQ.push_back(exp); tagQ.push_back(tag);
    obsValid = 1'b1;
  endtask

  task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    rdSel(0, addr, exp, tag);
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    tick();
    selQ.push_back(1); expQ.push_back({31'd0, exp}); tagQ.push_back(tag);
    obsValid = 1'b1;
  endtask

  task automatic setPin(input logic v);
    tick();
    nmiPin = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #160000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h04, 32'h0, "R1 pend");
    rd(8'h08, 32'h0, "R1 en");
    chkIrq(1'b0, "R1 irq");
    tick();
    rstN = 1'b1;
    // quiesce: mask then discard stale event
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R7 quiesce clear");
    idle(2);
    rd(8'h04, 32'h0, "R3 pin high no event");
    // R3 and R9 latency
    setPin(1'b0);
    rd(8'h04, 32'h0, "R9 edge1");
    rd(8'h04, 32'h0, "R9 edge2");
    rd(8'h04, 32'h1, "R3 low level sets");
    wr(8'h08, 32'h1);
    chkIrq(1'b0, "R9 irq lag");
    chkIrq(1'b1, "R9 irq up");
    // R8: clear while level active
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h1, "R8 set wins level low");
    wr(8'h08, 32'h0);
    chkIrq(1'b1, "R9 mask lag");
    chkIrq(1'b0, "R9 masked");
    // R4 level high
    wr(8'h00, 32'h2);
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R4 clear inactive");
    setPin(1'b1);
    idle(2);
    rd(8'h04, 32'h1, "R4 high level sets");
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h1, "R8 set wins level high");
    setPin(1'b0);
    idle(3);
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R4 released");
    // R2 and R6 rising
    wr(8'h00, 32'hA5A5_5A5F);
    rd(8'h00, 32'hA5A5_5A5F, "R2 readback");
    setPin(1'b1);
    idle(2);
    rd(8'h04, 32'h1, "R6 rising sets");
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R6 ack");
    idle(3);
    rd(8'h04, 32'h0, "R6 steady high");
    setPin(1'b0);
    idle(4);
    rd(8'h04, 32'h0, "R6 falling ignored");
    // R5 falling
    wr(8'h00, 32'hFFFF_FFFD);
    rd(8'h00, 32'hFFFF_FFFD, "R2 readback2");
    setPin(1'b1);
    idle(4);
    rd(8'h04, 32'h0, "R5 rising ignored");
    setPin(1'b0);
    idle(2);
    rd(8'h04, 32'h1, "R5 falling sets");
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R5 ack");
    idle(3);
    rd(8'h04, 32'h0, "R5 steady low");
    // R7 zero writes ignored
    setPin(1'b1);
    idle(3);
    setPin(1'b0);
    idle(4);
    rd(8'h04, 32'h1, "R7 pend set");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h1, "R7 write0 ignored");
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, 32'h1, "R7 bit0 only");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h1, "R9 en bit0 only");
    chkIrq(1'b1, "R9 irq after enable");
    // R11 unmapped
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R11 unmapped read");
    rd(8'h00, 32'hFFFF_FFFD, "R11 ctrl untouched");
    rd(8'h04, 32'h1, "R11 pend untouched");
    // R10 layouts
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h1);
    wr(8'h34, 32'h1);
    rd(8'h08, 32'h0, "R10 std enable at 08");
    rdSel(2, 8'h04, 32'h1, "R10 swap enable at 04");
    rdSel(3, 8'h34, 32'h1, "R10 legacy enable at 34");
    rd(8'h34, 32'h0, "R10 std 34 unmapped");
    rdSel(3, 8'h08, 32'h0, "R10 legacy 08 unmapped");
    rd(8'h04, 32'h0, "R10 std pend cleared");
    tick();
    tick();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule